// File: doc/BRIEF.md
# Buffer Read-Location Gather Engine

This block pulls selected byte ranges out of a codeword buffer and delivers them as a byte stream. Software first programs up to four read-location descriptors. Each descriptor holds a start offset, a byte count and an end-of-program flag. The flash side fills the buffer through a plain byte write port and then pulses a "buffer full" strobe.

A start pulse launches the gather. The engine works through the descriptors in register order. It reads the buffer through a synchronous read port and presents each requested byte on a valid/ready stream. When the descriptor carrying the end flag has been fully accepted downstream, the engine hands the buffer back by marking it empty.

Typical programs are:
- a split raw codeword: four contiguous pieces, alternating data and spare;
- a data-plus-spare read: two contiguous pieces;
- a single 512-byte parameter read.

Ranges that run past the end of the buffer are clipped and flagged. A program that never sets the end flag is stopped after the final register and flagged.

Top module: `rdloc_gather`

## Requirements
- R1: Descriptor slot i (i = 0..3) is written at configuration byte address 0xF20 + 4*i. The descriptor word holds the offset in bits 15:0, the size in bits 30:16 and the end flag in bit 31. A write to any other address (for example 0xF22 or 0xF30) changes no descriptor. A write while busy_o is high changes no descriptor.
- R2: A buf_full_i pulse clears buf_empty_o. start_i is ignored unless the engine is idle and buf_empty_o is low.
- R3: The engine services descriptors in slot order starting at slot 0. Each descriptor emits "size" bytes, taken from buffer addresses offset, offset+1, and so on.
- R4: After the descriptor with the end flag completes, no later slot is serviced. busy_o falls and buf_empty_o rises only once the final byte has been accepted.
- R5: A zero-size descriptor emits no bytes. A zero-size descriptor carrying the end flag still ends the program and releases the buffer.
- R6: Bytes at or beyond BUF_BYTES are never read. A descriptor whose offset+size exceeds BUF_BYTES emits only the in-range bytes and sets the sticky err_o, which only reset clears.
- R7: If slot 3 completes without any end flag, the engine stops, releases the buffer and sets err_o.
- R8: m_tlast_o is high only on the final byte of the descriptor that ends the program (end flag set, or slot 3). If that descriptor emits no bytes, m_tlast_o is never asserted.
- R9: While m_tvalid_o is high and m_tready_i is low, m_tvalid_o, m_tdata_o and m_tlast_o hold, and no buffer read is issued.
- R10: After reset m_tvalid_o, busy_o and err_o are low and buf_empty_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Descriptor register write strobe |
| cfg_addr_i | input | CFG_AW (12) | Configuration byte address |
| cfg_wdata_i | input | 32 | Descriptor word |
| buf_we_i | input | 1 | Buffer fill write strobe |
| buf_waddr_i | input | BUF_AW (10) | Buffer fill address |
| buf_wdata_i | input | 8 | Buffer fill byte |
| buf_full_i | input | 1 | Pulse: buffer holds a codeword |
| start_i | input | 1 | Pulse: run the descriptor program |
| m_tdata_o | output | 8 | Stream byte |
| m_tvalid_o | output | 1 | Stream byte valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tlast_o | output | 1 | Final byte of the program |
| busy_o | output | 1 | Program in progress |
| buf_empty_o | output | 1 | Buffer released / not yet filled |
| err_o | output | 1 | Sticky overrun or missing-end-flag error |

## Verification
The hardest situation to reach is back-pressure landing exactly on a descriptor boundary. At that moment a byte is still waiting at the output while the engine has already moved on to evaluating the next slot. The same applies to the release point, where the final byte is held and the buffer must not yet be freed. Each program in the vector table therefore runs with its own rotating ready mask, so stalls fall on different bytes, including the last one. Zero-size, clipped and unterminated programs are included so that the boundary paths are taken with no bytes in flight as well as with one.

// File: rtl/rdloc_pkg.sv
package rdloc_pkg;
  localparam int OFS_W  = 16;
  localparam int SIZE_W = 15;

  typedef struct packed {
    logic              last;
    logic [SIZE_W-1:0] size;
    logic [OFS_W-1:0]  offset;
  } loc_desc_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/rdloc_regs.sv
module rdloc_regs
  import rdloc_pkg::*;
#(
  parameter int N_LOC    = 4,
  parameter int CFG_AW   = 12,
  parameter int LOC_BASE = 'hF20
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [CFG_AW-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  input  logic                        lock_i,
  output loc_desc_t [N_LOC-1:0]       desc_o
);
  for (genvar i = 0; i < N_LOC; i++) begin : g_slot
    localparam logic [CFG_AW-1:0] SLOT_ADDR = CFG_AW'(LOC_BASE + 4 * i);
    loc_desc_t desc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        desc_q <= '0;
      end else if (we_i && !lock_i && addr_i == SLOT_ADDR) begin
        desc_q <= loc_desc_t'(wdata_i);
      end
    end

    assign desc_o[i] = desc_q;
  end
endmodule

// File: rtl/rdloc_buf.sv
module rdloc_buf #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read data only moves on an explicit read, so a stalled byte holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rdloc_seq.sv
module rdloc_seq
  import rdloc_pkg::*;
#(
  parameter int N_LOC = 4,
  parameter int DEPTH = 1024,
  parameter int IDX_W = (N_LOC > 1) ? $clog2(N_LOC) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  buf_full_i,
  input  loc_desc_t [N_LOC-1:0] desc_i,
  input  logic                  tready_i,
  output logic                  rd_en_o,
  output logic [OFS_W-1:0]      rd_addr_o,
  output logic                  tvalid_o,
  output logic                  tlast_o,
  output logic                  busy_o,
  output logic                  buf_empty_o,
  output logic                  err_o
);
  localparam logic [OFS_W:0] DEPTH_X = (OFS_W + 1)'(DEPTH);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OFS_W-1:0]  addr_q;
  logic [SIZE_W-1:0] remain_q;
  logic              term_q;
  logic              tvalid_q, tlast_q, full_q, err_q;

  loc_desc_t         cur;
  logic [OFS_W:0]    end_w, avail_w;
  logic              over_w, term_w, nolast_w, release_w, rd_en_w;
  logic [SIZE_W-1:0] cnt_w;

  always_comb begin
    cur      = desc_i[idx_q];
    end_w    = {1'b0, cur.offset} + (OFS_W + 1)'(cur.size);
    avail_w  = ({1'b0, cur.offset} >= DEPTH_X) ? '0 : DEPTH_X - {1'b0, cur.offset};
    over_w   = end_w > DEPTH_X;
    cnt_w    = over_w ? SIZE_W'(avail_w) : cur.size;
    term_w   = cur.last || (idx_q == IDX_W'(N_LOC - 1));
    nolast_w = !cur.last && (idx_q == IDX_W'(N_LOC - 1));
  end

  assign rd_en_w   = (state_q == ST_RUN) && (remain_q != '0) && (!tvalid_q || tready_i);
  assign release_w = (state_q == ST_DRAIN) && (!tvalid_q || tready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      addr_q   <= '0;
      remain_q <= '0;
      term_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && full_q) begin
            idx_q   <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          addr_q   <= cur.offset;
          remain_q <= cnt_w;
          term_q   <= term_w;
          if (over_w || nolast_w) err_q <= 1'b1;
          state_q  <= ST_RUN;
        end
        ST_RUN: begin
          if (rd_en_w) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
          end else if (remain_q == '0) begin
            if (term_q) begin
              state_q <= ST_DRAIN;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_DRAIN: begin
          if (release_w) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // output stage: one byte in flight, loaded by each buffer read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvalid_q <= 1'b0;
      tlast_q  <= 1'b0;
    end else if (rd_en_w) begin
      tvalid_q <= 1'b1;
      tlast_q  <= term_q && (remain_q == SIZE_W'(1));
    end else if (tready_i) begin
      tvalid_q <= 1'b0;
      tlast_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else if (buf_full_i) full_q <= 1'b1;
    else if (release_w) full_q <= 1'b0;
  end

  assign rd_en_o     = rd_en_w;
  assign rd_addr_o   = addr_q;
  assign tvalid_o    = tvalid_q;
  assign tlast_o     = tlast_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign buf_empty_o = !full_q;
  assign err_o       = err_q;
endmodule

// File: rtl/rdloc_gather.sv
module rdloc_gather
  import rdloc_pkg::*;
#(
  parameter int N_LOC     = 4,
  parameter int BUF_BYTES = 1024,
  parameter int CFG_AW    = 12,
  parameter int LOC_BASE  = 'hF20,
  parameter int BUF_AW    = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              buf_we_i,
  input  logic [BUF_AW-1:0] buf_waddr_i,
  input  logic [7:0]        buf_wdata_i,
  input  logic              buf_full_i,
  input  logic              start_i,
  output logic [7:0]        m_tdata_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic              m_tlast_o,
  output logic              busy_o,
  output logic              buf_empty_o,
  output logic              err_o
);
  loc_desc_t [N_LOC-1:0] desc;
  logic                  rd_en;
  logic [OFS_W-1:0]      rd_addr;
  logic                  busy;

  rdloc_regs #(
    .N_LOC   (N_LOC),
    .CFG_AW  (CFG_AW),
    .LOC_BASE(LOC_BASE)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .lock_i (busy),
    .desc_o (desc)
  );

  rdloc_buf #(
    .DEPTH(BUF_BYTES),
    .AW   (BUF_AW)
  ) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (buf_we_i),
    .waddr_i(buf_waddr_i),
    .wdata_i(buf_wdata_i),
    .re_i   (rd_en),
    .raddr_i(rd_addr[BUF_AW-1:0]),
    .rdata_o(m_tdata_o)
  );

  rdloc_seq #(
    .N_LOC(N_LOC),
    .DEPTH(BUF_BYTES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .buf_full_i (buf_full_i),
    .desc_i     (desc),
    .tready_i   (m_tready_i),
    .rd_en_o    (rd_en),
    .rd_addr_o  (rd_addr),
    .tvalid_o   (m_tvalid_o),
    .tlast_o    (m_tlast_o),
    .busy_o     (busy),
    .buf_empty_o(buf_empty_o),
    .err_o      (err_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/rdloc_gather_chk.sv
module rdloc_gather_chk #(
  parameter int DEPTH = 1024
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tvalid_i,
  input logic        tready_i,
  input logic [7:0]  tdata_i,
  input logic        tlast_i,
  input logic        busy_i,
  input logic        buf_empty_i,
  input logic        err_i,
  input logic        rd_en_i,
  input logic [15:0] rd_addr_i
);
  assert_hold_stream_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_i && !tready_i |=> tvalid_i && $stable(tdata_i) && $stable(tlast_i));

  assert_no_read_on_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_i && !tready_i |-> !rd_en_i);

  assert_read_in_bounds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> rd_addr_i < 16'(DEPTH));

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  assert_release_drained_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_i) |-> !tvalid_i && !busy_i);

  assert_valid_only_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_i |-> busy_i);

  assert_start_needs_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && buf_empty_i |=> !busy_i);
endmodule

bind rdloc_gather rdloc_gather_chk #(.DEPTH(BUF_BYTES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tvalid_i   (m_tvalid_o),
  .tready_i   (m_tready_i),
  .tdata_i    (m_tdata_o),
  .tlast_i    (m_tlast_o),
  .busy_i     (busy_o),
  .buf_empty_i(buf_empty_o),
  .err_i      (err_o),
  .rd_en_i    (rd_en),
  .rd_addr_i  (rd_addr)
);

// File: tb/rdloc_gather_bench.sv
`timescale 1ns/1ps
module rdloc_gather_bench;
  localparam int BUF = 1024;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0, buf_we = 1'b0, buf_full = 1'b0, start = 1'b0, tready = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [9:0]  buf_waddr = '0;
  logic [7:0]  buf_wdata = '0, tdata;
  logic        tvalid, tlast, busy, buf_empty, err;

  always #2 clk = ~clk;

  rdloc_gather u_rdloc_gather (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .buf_we_i(buf_we), .buf_waddr_i(buf_waddr), .buf_wdata_i(buf_wdata),
    .buf_full_i(buf_full), .start_i(start),
    .m_tdata_o(tdata), .m_tvalid_o(tvalid), .m_tready_i(tready), .m_tlast_o(tlast),
    .busy_o(busy), .buf_empty_o(buf_empty), .err_o(err)
  );

  int checks = 0, fails = 0;

  function automatic logic [31:0] mk(int off, int sz, bit last);
    return {last, 15'(sz), 16'(off)};
  endfunction

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  typedef struct packed {
    logic [31:0] d0, d1, d2, d3;
    logic [7:0]  rmask;
    logic        err;
  } case_t;

  localparam int N_CASE = 7;
  localparam case_t CASES [N_CASE] = '{
    '{mk(0, 20, 0),    mk(20, 6, 0),  mk(26, 20, 0), mk(46, 6, 1), 8'hFF,       1'b0},
    '{mk(0, 30, 0),    mk(30, 8, 1),  mk(100, 5, 0), mk(200, 5, 1), 8'b0101_0101, 1'b0},
    '{mk(0, 512, 1),   mk(3, 3, 0),   mk(3, 3, 0),   mk(3, 3, 1), 8'b1011_0111, 1'b0},
    '{mk(10, 4, 0),    mk(0, 0, 1),   mk(3, 3, 1),   mk(3, 3, 1), 8'b0011_0011, 1'b0},
    '{mk(1020, 10, 1), mk(0, 5, 1),   mk(0, 5, 1),   mk(0, 5, 1), 8'b1100_1101, 1'b1},
    '{mk(5, 3, 0),     mk(0, 0, 0),   mk(900, 2, 0), mk(7, 1, 0), 8'b0110_1110, 1'b1},
    '{mk(2000, 5, 1),  mk(0, 4, 1),   mk(0, 4, 1),   mk(0, 4, 1), 8'hFF,       1'b1}
  };
  string tags [N_CASE] = '{"R3", "R4", "R3", "R5", "R6", "R7", "R6"};

  logic [7:0] exp_b [2048];
  int exp_n, exp_last;
  logic [7:0] got_b [2048];
  int got_n, got_last, n_tlast, stable_bad;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected output derived from the requirements only
  task automatic model(input logic [31:0] d [4]);
    exp_n = 0; exp_last = -1;
    for (int k = 0; k < 4; k++) begin
      int off, sz, avail, cnt;
      off = int'(d[k][15:0]); sz = int'(d[k][30:16]);
      avail = (off >= BUF) ? 0 : BUF - off;
      cnt = (sz > avail) ? avail : sz;
      for (int j = 0; j < cnt; j++) begin
        exp_b[exp_n] = pat(off + j);
        exp_n++;
      end
      if (d[k][31] || k == 3) begin
        if (cnt > 0) exp_last = exp_n - 1;
        break;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic cfg_write(int a, logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 12'(a); cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_full();
    @(negedge clk); buf_full = 1'b1;
    @(negedge clk); buf_full = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic collect(logic [7:0] rmask);
    int cyc = 0;
    bit prev_stall = 0;
    logic [7:0] prev_d = '0;
    logic prev_l = 1'b0;
    got_n = 0; got_last = -1; n_tlast = 0; stable_bad = 0;
    forever begin
      if (!busy) break;
      tready = rmask[cyc % 8];
      cyc++;
      if (prev_stall && (!tvalid || tdata != prev_d || tlast != prev_l)) stable_bad++;
      if (tvalid && tready) begin
        got_b[got_n] = tdata;
        if (tlast) begin got_last = got_n; n_tlast++; end
        got_n++;
      end
      prev_stall = tvalid && !tready;
      prev_d = tdata; prev_l = tlast;
      if (cyc > 20000) begin
        check(0, "R4", "program never ended", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    tready = 1'b0;
  endtask

  task automatic compare(string req, string tag, bit exp_err);
    int bad = -1;
    check(got_n == exp_n, req, "byte count", got_n, exp_n);
    for (int i = 0; i < got_n && i < exp_n; i++)
      if (got_b[i] !== exp_b[i] && bad < 0) bad = i;
    if (bad >= 0) check(0, req, "byte value", int'(got_b[bad]), int'(exp_b[bad]));
    else check(1, req, "byte value", 0, 0);
    check(n_tlast == ((exp_last >= 0) ? 1 : 0) && got_last == exp_last, "R8",
          "tlast position", got_last, exp_last);
    check(stable_bad == 0, "R9", "stall stability", stable_bad, 0);
    check(buf_empty === 1'b1 && busy === 1'b0, tag, "buffer released", int'(buf_empty), 1);
    check(err === exp_err, tag, "err flag", int'(err), int'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R4", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d [4];
    do_reset();
    @(negedge clk);
    check(tvalid === 1'b0 && busy === 1'b0 && buf_empty === 1'b1 && err === 1'b0,
          "R10", "reset state", {tvalid, busy, buf_empty, err}, 4'b0010);

    for (int a = 0; a < BUF; a++) begin
      @(negedge clk); buf_we = 1'b1; buf_waddr = 10'(a); buf_wdata = pat(a);
    end
    @(negedge clk); buf_we = 1'b0;

    // R2: start with buffer still empty
    cfg_write('hF20, mk(0, 4, 1));
    pulse_start();
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && tvalid === 1'b0, "R2", "start ignored when empty", int'(busy), 0);
    pulse_full();
    check(buf_empty === 1'b0, "R2", "full pulse clears empty", int'(buf_empty), 0);

    for (int c = 0; c < N_CASE; c++) begin
      do_reset();
      d = '{CASES[c].d0, CASES[c].d1, CASES[c].d2, CASES[c].d3};
      for (int k = 0; k < 4; k++) cfg_write('hF20 + 4 * k, d[k]);
      model(d);
      pulse_full();
      pulse_start();
      collect(CASES[c].rmask);
      compare("R3", tags[c], CASES[c].err);
    end

    // R1: misaligned and out-of-range slot writes are ignored
    do_reset();
    cfg_write('hF20, mk(0, 3, 1));
    cfg_write('hF22, mk(50, 9, 1));
    cfg_write('hF30, mk(60, 9, 1));
    d = '{mk(0, 3, 1), 32'h0, 32'h0, 32'h0};
    model(d);
    pulse_full();
    pulse_start();
    collect(8'hFF);
    compare("R1", "R1", 1'b0);

    // R1: write while busy is ignored
    do_reset();
    cfg_write('hF20, mk(0, 40, 1));
    d = '{mk(0, 40, 1), 32'h0, 32'h0, 32'h0};
    model(d);
    pulse_full();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cfg_we = 1'b1; cfg_addr = 12'hF20; cfg_wdata = mk(100, 2, 1);
    @(negedge clk); cfg_we = 1'b0;
    collect(8'b0000_0101);
    compare("R1", "R1", 1'b0);

    // R2: start after release is ignored until the next full pulse
    pulse_start();
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R2", "start ignored after release", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule